// File: doc/BRIEF.md
# Buffered Performance Error Counter Bank

This block gathers receive-side error events for line performance monitoring. Four full-width saturating counters track code violations, framing-bit errors, CRC-6 errors and errored blocks. A fifth, combined register holds two small saturating sub-counters. One counts multiframes received while the framer is out of alignment. The other counts changes of frame alignment. Each event arrives as a single-cycle strobe from an upstream detector.

Software never reads a live counter. Every counter has a holding buffer, and a snapshot copies all live counts into their buffers and clears the live counts in the same clock edge. The mode select chooses what triggers the snapshot: a periodic one-second tick, or a write strobe from software that acts as a handshake. An event that lands on the snapshot edge is not lost. It becomes the first count of the new period. A one-cycle update pulse follows each snapshot so that software or an interrupt block knows fresh values are ready.

Top module: `perf_err_bank`

## Requirements
- R1: After reset, all five buffer outputs read zero and `buf_upd_o` is low.
- R2: Each cycle with an event strobe high and no snapshot adds exactly one to that strobe's live counter, and the total shows in the matching buffer after the next snapshot.
- R3: The four full counters saturate at 2^CNT_W-1 and hold that value until a snapshot clears them; they never wrap.
- R4: `aux_buf_o` carries the out-of-alignment multiframe count in bits [ASY_W-1:0] and the alignment-change count in bits [ASY_W+COFA_W-1:ASY_W], with all higher bits zero; each sub-field saturates on its own at 2^ASY_W-1 and 2^COFA_W-1.
- R5: With `mode_i` = 0, a high `sec_tick_i` on a clock edge copies every live count into its buffer and clears the live counts; the buffers show the copy from the following cycle.
- R6: With `mode_i` = 1, a high `hs_wr_i` on a clock edge performs the same copy and clear.
- R7: With `mode_i` = 0, `hs_wr_i` has no effect, and with `mode_i` = 1, `sec_tick_i` has no effect: no buffer changes and no update pulse follows.
- R8: An event that coincides with a snapshot is kept: the buffer takes the count from before the clear, and the live counter restarts at one.
- R9: `buf_upd_o` is high for exactly the one cycle that follows each snapshot edge, and low at all other times.
- R10: Between snapshots the buffers hold their values, whatever events arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| code_viol_i | input | 1 | Code-violation event strobe |
| frame_bit_i | input | 1 | Framing-bit error event strobe |
| crc6_i | input | 1 | CRC-6 error event strobe |
| blk_err_i | input | 1 | Errored-block event strobe |
| oos_mf_i | input | 1 | Multiframe received out of alignment strobe |
| realign_i | input | 1 | Change-of-frame-alignment strobe |
| sec_tick_i | input | 1 | One-second tick (used when mode_i = 0) |
| mode_i | input | 1 | Snapshot source: 0 = tick, 1 = software handshake |
| hs_wr_i | input | 1 | Handshake write strobe (used when mode_i = 1) |
| code_viol_buf_o | output | CNT_W | Buffered code-violation count |
| frame_bit_buf_o | output | CNT_W | Buffered framing-bit error count |
| crc6_buf_o | output | CNT_W | Buffered CRC-6 error count |
| blk_err_buf_o | output | CNT_W | Buffered errored-block count |
| aux_buf_o | output | CNT_W | Buffered combined sub-field register |
| buf_upd_o | output | 1 | One-cycle pulse after each snapshot |

## Verification
The bench builds the block with CNT_W = 8 and keeps ASY_W = 6 and COFA_W = 2. With these values a full counter saturates after 255 events, so a few hundred cycles of continuous strobes reach saturation and then hold there. The two sub-fields also fill the combined register exactly, which exposes any packing or padding slip at the top bit. Snapshots that coincide with events are made both from a low count and from saturation, and they are made in both modes.

// File: rtl/perf_err_pkg.sv
package perf_err_pkg;

    // Snapshot trigger source selected by the mode input
    typedef enum logic {
        SNAP_SRC_TICK = 1'b0,
        SNAP_SRC_HS   = 1'b1
    } snap_src_e;

    // Number of full-width counters in the bank
    localparam int unsigned NUM_FULL = 4;

endpackage

// File: rtl/perf_snap_ctrl.sv
module perf_snap_ctrl
    import perf_err_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic src_sel_i,
    input  logic tick_i,
    input  logic hs_wr_i,
    output logic snap_o,
    output logic upd_o
);

    typedef struct packed {
        logic upd;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    snap_src_e  src;

    always_comb begin
        src    = snap_src_e'(src_sel_i);
        snap_o = (src == SNAP_SRC_HS) ? hs_wr_i : tick_i;
        st_d   = st_q;
        st_d.upd = snap_o;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign upd_o = st_q.upd;

    // R9
    upd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        snap_o |=> upd_o);
    // R9
    upd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !snap_o |=> !upd_o);
    // R7
    hs_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!src_sel_i && !tick_i && hs_wr_i) |=> !upd_o);
    // R7
    tick_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_sel_i && tick_i && !hs_wr_i) |=> !upd_o);

endmodule

// File: rtl/perf_sat_ctr.sv
module perf_sat_ctr #(
    parameter int unsigned W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         evt_i,
    input  logic         snap_i,
    output logic [W-1:0] hold_o
);

    localparam logic [W-1:0] MAX_VAL = {W{1'b1}};
    localparam logic [W-1:0] ONE     = W'(1);

    typedef struct packed {
        logic [W-1:0] live;
        logic [W-1:0] hold;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (snap_i) begin
            st_d.hold = st_q.live;
            st_d.live = evt_i ? ONE : '0;
        end else if (evt_i && (st_q.live != MAX_VAL)) begin
            st_d.live = st_q.live + ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign hold_o = st_q.hold;

    // R3
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i && !snap_i && st_q.live == MAX_VAL) |=> st_q.live == MAX_VAL);
    // R8
    carry_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (snap_i && evt_i) |=> st_q.live == ONE);
    // R5
    snap_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        snap_i |=> st_q.hold == $past(st_q.live));
    // R10
    hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !snap_i |=> $stable(st_q.hold));

endmodule

// File: rtl/perf_err_bank.sv
module perf_err_bank
    import perf_err_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ASY_W  = 6,
    parameter int unsigned COFA_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             code_viol_i,
    input  logic             frame_bit_i,
    input  logic             crc6_i,
    input  logic             blk_err_i,
    input  logic             oos_mf_i,
    input  logic             realign_i,
    input  logic             sec_tick_i,
    input  logic             mode_i,
    input  logic             hs_wr_i,
    output logic [CNT_W-1:0] code_viol_buf_o,
    output logic [CNT_W-1:0] frame_bit_buf_o,
    output logic [CNT_W-1:0] crc6_buf_o,
    output logic [CNT_W-1:0] blk_err_buf_o,
    output logic [CNT_W-1:0] aux_buf_o,
    output logic             buf_upd_o
);

    localparam int unsigned AUX_USED = ASY_W + COFA_W;

    logic                snap;
    logic [NUM_FULL-1:0] full_evt;
    logic [CNT_W-1:0]    full_hold [NUM_FULL];
    logic [ASY_W-1:0]    asy_hold;
    logic [COFA_W-1:0]   cofa_hold;

    initial begin
        cfg_width_chk: assert (CNT_W >= AUX_USED);
    end

    perf_snap_ctrl u_snap (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .src_sel_i (mode_i),
        .tick_i    (sec_tick_i),
        .hs_wr_i   (hs_wr_i),
        .snap_o    (snap),
        .upd_o     (buf_upd_o)
    );

    assign full_evt = {blk_err_i, crc6_i, frame_bit_i, code_viol_i};

    for (genvar g = 0; g < NUM_FULL; g++) begin : g_full
        perf_sat_ctr #(.W(CNT_W)) u_ctr (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .evt_i  (full_evt[g]),
            .snap_i (snap),
            .hold_o (full_hold[g])
        );
    end

    perf_sat_ctr #(.W(ASY_W)) u_asy (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .evt_i  (oos_mf_i),
        .snap_i (snap),
        .hold_o (asy_hold)
    );

    perf_sat_ctr #(.W(COFA_W)) u_cofa (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .evt_i  (realign_i),
        .snap_i (snap),
        .hold_o (cofa_hold)
    );

    assign code_viol_buf_o = full_hold[0];
    assign frame_bit_buf_o = full_hold[1];
    assign crc6_buf_o      = full_hold[2];
    assign blk_err_buf_o   = full_hold[3];
    assign aux_buf_o       = CNT_W'({cofa_hold, asy_hold});

    // R4
    aux_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (aux_buf_o >> AUX_USED) == '0);
    // R10
    bufs_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !buf_upd_o |-> $stable(code_viol_buf_o) && $stable(aux_buf_o));

endmodule

// File: tb/perf_err_bank_tb.sv
module perf_err_bank_tb;

    localparam int unsigned W      = 8;
    localparam int unsigned ASY_W  = 6;
    localparam int unsigned COFA_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] ev = '0;   // 0 code viol, 1 frame bit, 2 crc6, 3 blk err, 4 oos mf, 5 realign
    logic tick = 1'b0, mode = 1'b0, hsw = 1'b0;
    logic [W-1:0] b0, b1, b2, b3, baux;
    logic upd;

    always #10 clk = ~clk;   // 50 MHz

    perf_err_bank #(.CNT_W(W), .ASY_W(ASY_W), .COFA_W(COFA_W)) u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .code_viol_i(ev[0]), .frame_bit_i(ev[1]), .crc6_i(ev[2]), .blk_err_i(ev[3]),
        .oos_mf_i(ev[4]), .realign_i(ev[5]),
        .sec_tick_i(tick), .mode_i(mode), .hs_wr_i(hsw),
        .code_viol_buf_o(b0), .frame_bit_buf_o(b1), .crc6_buf_o(b2), .blk_err_buf_o(b3),
        .aux_buf_o(baux), .buf_upd_o(upd)
    );

    typedef struct {
        logic [W-1:0] e0, e1, e2, e3, eaux;
        logic         eupd;
        string        tag;
    } exp_t;

    exp_t q[$];
    int n_cmp = 0, n_bad = 0;
    int mcnt[6];
    int mbuf[6];
    int mmax[6];
    bit done = 0;

    task automatic compare(input exp_t x);
        n_cmp++;
        if (b0 !== x.e0 || b1 !== x.e1 || b2 !== x.e2 || b3 !== x.e3 ||
            baux !== x.eaux || upd !== x.eupd) begin
            n_bad++;
            $display("FAIL %s: got %h %h %h %h aux=%h upd=%b, expected %h %h %h %h aux=%h upd=%b",
                     x.tag, b0, b1, b2, b3, baux, upd, x.e0, x.e1, x.e2, x.e3, x.eaux, x.eupd);
        end
    endtask

    // Driver: applies one cycle of stimulus and pushes the expected result
    task automatic step(input logic [5:0] e, input logic tk, input logic md,
                        input logic hw, input string tag);
        exp_t x;
        bit sn;
        @(negedge clk);
        ev = e; tick = tk; mode = md; hsw = hw;
        sn = md ? hw : tk;
        for (int i = 0; i < 6; i++) begin
            if (sn) begin
                mbuf[i] = mcnt[i];
                mcnt[i] = e[i] ? 1 : 0;
            end else if (e[i] && mcnt[i] < mmax[i]) begin
                mcnt[i]++;
            end
        end
        x.e0 = W'(mbuf[0]); x.e1 = W'(mbuf[1]); x.e2 = W'(mbuf[2]); x.e3 = W'(mbuf[3]);
        x.eaux = W'(mbuf[4] + (mbuf[5] << ASY_W));
        x.eupd = sn;
        x.tag = tag;
        q.push_back(x);
    endtask

    // Monitor: pops one expected item per clock
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) compare(q.pop_front());
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        exp_t z;
        for (int i = 0; i < 6; i++) begin
            mcnt[i] = 0; mbuf[i] = 0;
            mmax[i] = (i < 4) ? (1 << W) - 1 : (i == 4 ? (1 << ASY_W) - 1 : (1 << COFA_W) - 1);
        end
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        z.e0 = '0; z.e1 = '0; z.e2 = '0; z.e3 = '0; z.eaux = '0; z.eupd = 1'b0; z.tag = "R1";
        compare(z);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 distinct patterns in tick mode, then R5 tick snapshot
        step(6'b000001, 0, 0, 0, "R2");
        step(6'b000011, 0, 0, 0, "R2");
        step(6'b010111, 0, 0, 0, "R2");
        step(6'b101111, 0, 0, 0, "R2");
        step(6'b011000, 0, 0, 0, "R10");
        step(6'b000000, 1, 0, 0, "R5");
        step(6'b000000, 0, 0, 0, "R9");
        // R8 event on the snapshot edge is carried
        step(6'b000101, 0, 0, 0, "R2");
        step(6'b111111, 1, 0, 0, "R8");
        step(6'b000000, 0, 0, 0, "R9");
        step(6'b000000, 1, 0, 0, "R8");
        // R7 handshake ignored in tick mode
        step(6'b000010, 0, 0, 1, "R7");
        step(6'b000000, 0, 0, 1, "R7");
        step(6'b000000, 0, 0, 0, "R7");
        // R6 handshake mode, R7 tick ignored there
        step(6'b100100, 0, 1, 0, "R6");
        step(6'b000000, 1, 1, 0, "R7");
        step(6'b000000, 0, 1, 0, "R7");
        step(6'b000001, 0, 1, 1, "R6");
        step(6'b000000, 0, 1, 0, "R9");
        step(6'b000000, 0, 1, 1, "R8");
        // R3 and R4 saturation in every counter
        for (int k = 0; k < 300; k++) step(6'b111111, 0, 1, 0, "R10");
        step(6'b000000, 0, 1, 1, "R3");
        for (int k = 0; k < 70; k++) step(6'b110000, 0, 0, 0, "R10");
        step(6'b000000, 1, 0, 0, "R4");
        // R4 sub-fields saturate independently: only oos mf to max
        for (int k = 0; k < 80; k++) step(6'b010000, 0, 0, 0, "R10");
        step(6'b100000, 0, 0, 0, "R10");
        step(6'b000000, 1, 0, 0, "R4");
        // R8 snapshot at saturation with a coincident event
        for (int k = 0; k < 260; k++) step(6'b000001, 0, 1, 0, "R3");
        step(6'b000001, 0, 1, 1, "R8");
        step(6'b000000, 0, 1, 1, "R8");
        step(6'b000000, 0, 1, 0, "R9");
        repeat (4) @(posedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule